// File: doc/BRIEF.md
# SPI Slave-Programming Frame Engine

This block is an SPI master that feeds a target device's slave programming port with fixed-length frames. A host loads an 8-bit command, a 16-byte payload, a read flag, a poll limit and a clock divider setting, then pulses `start`. The engine polls the target's hardware status, sends the command frame, and for read operations polls again and issues a separate read-out frame that clocks 16 response bytes back into a host-visible register.

Status polling uses single-byte frames of 0xFF. The response to the first status frame of each poll is thrown away. Later responses are tested for a ready bit until it is set or the poll limit runs out. Every other frame is one command byte followed by exactly 16 data bytes. The clock idles high and data is sampled on the rising edge. Bits are sent most significant first.

The host side is a plain register interface: `start` is accepted only while `busy` is low, and `busy` stays high until the single-cycle `done` pulse. There is no streaming back-pressure. A `start` that arrives during an operation is dropped, and the host must wait for `done` before it reads `rd_payload` or `timeout_err`.

Top module: `spi_prog_engine`

## Requirements
- R1: After reset, `cs_n`=1, `sclk`=1, `busy`=0, `done`=0 and `timeout_err`=0.
- R2: `sclk` is high whenever `cs_n` is high. `mosi` changes only at a falling `sclk` edge or before the first one, and `miso` is sampled on the rising edge.
- R3: Each `sclk` low phase and high phase lasts `clk_half` system cycles. A `clk_half` of 0 behaves as 1.
- R4: Every operation starts with a status frame of 8 bits carrying 0xFF, and its response is ignored. Further 0xFF status frames follow until one returns bit 1 (value 0x02) set. The other bits of the status byte have no effect.
- R5: A command frame is 136 bits: `op_cmd` first, then payload byte 0 (`wr_payload[7:0]`) through byte 15 (`wr_payload[127:120]`), each byte MSB first.
- R6: When `op_read`=1, the command frame is followed by a fresh poll (as in R4) and then a 136-bit frame of 0x05 plus 16 zero bytes. The 8 bits received after the 0x05 byte form `rd_payload[7:0]`, the next 8 form `rd_payload[15:8]`, and so on.
- R7: `cs_n` is low from before the first bit of a frame to after its last bit. Between frames of one operation it is high for at least 4×`clk_half` system cycles, which is two SCLK periods.
- R8: If `poll_limit` tested status bytes in a row are not ready, the operation ends with `timeout_err`=1 and sends no further frame. A `poll_limit` of 0 behaves as 1.
- R9: `start` and the operand inputs are ignored while `busy` is high.
- R10: `done` is a one-cycle pulse in the cycle `busy` falls. `timeout_err` and `rd_payload` keep their values until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| op_cmd | input | 8 | Command byte |
| op_read | input | 1 | Operation also reads 16 bytes back |
| wr_payload | input | 128 | Payload, byte i at bits 8i+7..8i |
| poll_limit | input | 8 | Maximum tested status bytes per poll |
| clk_half | input | 8 | SCLK half period in system cycles |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| timeout_err | output | 1 | Last operation hit the poll limit |
| rd_payload | output | 128 | Read-back bytes, byte i at bits 8i+7..8i |
| sclk | output | 1 | SPI clock, idles high |
| mosi | output | 1 | Serial data to target |
| cs_n | output | 1 | Active-low chip select |
| miso | input | 1 | Serial data from target |

## Verification
The assertions assume that `rst_n` is held low for at least one clock and that `miso` only changes while `sclk` is low. The bench's target model follows this by updating `miso` on falling `sclk` edges only. They also assume that `clk_half` is constant while `busy` is high, which the engine guarantees by latching it at `start`. The bench changes it only between operations. The sweep covers divider settings 1 to 3, several not-ready counts on both sides of the limit, both operation kinds, a zero limit and a `start` made during an operation.

// File: rtl/spe_pkg.sv
package spe_pkg;
  typedef enum logic [2:0] {
    K_POLL0,
    K_POLLN,
    K_CMD,
    K_READ,
    K_DONE
  } frame_kind_t;

  localparam logic [7:0] STATUS_BYTE = 8'hFF;
  localparam logic [7:0] READ_OPCODE = 8'h05;
endpackage

// File: rtl/spe_byte_order.sv
module spe_byte_order #(
  parameter int NBYTES = 16
) (
  input  logic [8*NBYTES-1:0] din,
  output logic [8*NBYTES-1:0] dout
);
  for (genvar i = 0; i < NBYTES; i++) begin : g_swap
    assign dout[8*i +: 8] = din[8*(NBYTES-1-i) +: 8];
  end
endmodule

// File: rtl/spe_frame_shifter.sv
module spe_frame_shifter #(
  parameter int FRAME_BITS = 136,
  parameter int RX_BITS    = 128,
  parameter int DIV_W      = 8,
  localparam int BW        = $clog2(FRAME_BITS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  go,
  input  logic [BW-1:0]         nbits,
  input  logic [FRAME_BITS-1:0] tx_in,
  input  logic [DIV_W-1:0]      half,
  input  logic                  miso,
  output logic                  sclk,
  output logic                  mosi,
  output logic                  cs_n,
  output logic                  fin,
  output logic [RX_BITS-1:0]    rx
);
  typedef enum logic [1:0] {F_IDLE, F_LEAD, F_LOW, F_HIGH} fstate_t;

  fstate_t               st;
  logic [FRAME_BITS-1:0] tx;
  logic [BW-1:0]         left;
  logic [DIV_W-1:0]      cnt;

  assign mosi = tx[FRAME_BITS-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= F_IDLE;
      tx   <= '0;
      left <= '0;
      cnt  <= '0;
      sclk <= 1'b1;
      cs_n <= 1'b1;
      fin  <= 1'b0;
      rx   <= '0;
    end else begin
      fin <= 1'b0;
      unique case (st)
        F_IDLE: if (go) begin
          tx   <= tx_in;
          left <= nbits;
          cs_n <= 1'b0;
          cnt  <= half - 1'b1;
          st   <= F_LEAD;
        end
        F_LEAD: if (cnt == '0) begin
          sclk <= 1'b0;
          cnt  <= half - 1'b1;
          st   <= F_LOW;
        end else cnt <= cnt - 1'b1;
        F_LOW: if (cnt == '0) begin
          sclk <= 1'b1;
          rx   <= {rx[RX_BITS-2:0], miso};
          cnt  <= half - 1'b1;
          st   <= F_HIGH;
        end else cnt <= cnt - 1'b1;
        F_HIGH: if (cnt == '0) begin
          if (left == BW'(1)) begin
            cs_n <= 1'b1;
            fin  <= 1'b1;
            st   <= F_IDLE;
          end else begin
            sclk <= 1'b0;
            tx   <= {tx[FRAME_BITS-2:0], 1'b0};
            left <= left - 1'b1;
            cnt  <= half - 1'b1;
            st   <= F_LOW;
          end
        end else cnt <= cnt - 1'b1;
        default: st <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_prog_engine.sv
module spi_prog_engine
  import spe_pkg::*;
#(
  parameter int NBYTES    = 16,
  parameter int DIV_W     = 8,
  parameter int LIM_W     = 8,
  parameter int READY_BIT = 1,
  localparam int PB       = 8 * NBYTES,
  localparam int FB       = 8 + PB,
  localparam int BW       = $clog2(FB + 1),
  localparam int GW       = DIV_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       op_cmd,
  input  logic             op_read,
  input  logic [PB-1:0]    wr_payload,
  input  logic [LIM_W-1:0] poll_limit,
  input  logic [DIV_W-1:0] clk_half,
  output logic             busy,
  output logic             done,
  output logic             timeout_err,
  output logic [PB-1:0]    rd_payload,
  output logic             sclk,
  output logic             mosi,
  output logic             cs_n,
  input  logic             miso
);
  typedef enum logic [1:0] {T_IDLE, T_FRAME, T_GAP} tstate_t;

  tstate_t          st;
  frame_kind_t      cur_k, next_k, pend_k;
  logic [7:0]       cmd_q;
  logic             read_q, hit_limit, go, fin;
  logic [PB-1:0]    pay_q, pay_rev, rx, rx_ordered;
  logic [LIM_W-1:0] lim_q, polls;
  logic [DIV_W-1:0] half_q;
  logic [GW-1:0]    gap;
  logic [FB-1:0]    tx_vec;
  logic [BW-1:0]    nbits;

  spe_byte_order #(.NBYTES(NBYTES)) u_tx_order (.din(pay_q), .dout(pay_rev));
  spe_byte_order #(.NBYTES(NBYTES)) u_rx_order (.din(rx), .dout(rx_ordered));

  always_comb begin
    unique case (cur_k)
      K_CMD:   begin tx_vec = {cmd_q, pay_rev};          nbits = BW'(FB); end
      K_READ:  begin tx_vec = {READ_OPCODE, {PB{1'b0}}}; nbits = BW'(FB); end
      default: begin tx_vec = {STATUS_BYTE, {PB{1'b0}}}; nbits = BW'(8);  end
    endcase
  end

  spe_frame_shifter #(.FRAME_BITS(FB), .RX_BITS(PB), .DIV_W(DIV_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .go(go), .nbits(nbits), .tx_in(tx_vec),
    .half(half_q), .miso(miso), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
    .fin(fin), .rx(rx)
  );

  logic             last_poll;
  logic [LIM_W-1:0] lim_eff;
  assign lim_eff   = (lim_q == '0) ? LIM_W'(1) : lim_q;
  assign last_poll = ({1'b0, polls} + 1'b1) >= {1'b0, lim_eff};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= T_IDLE;
      cur_k       <= K_POLL0;
      next_k      <= K_DONE;
      pend_k      <= K_CMD;
      cmd_q       <= '0;
      read_q      <= 1'b0;
      pay_q       <= '0;
      lim_q       <= '0;
      half_q      <= DIV_W'(1);
      polls       <= '0;
      gap         <= '0;
      go          <= 1'b0;
      busy        <= 1'b0;
      done        <= 1'b0;
      hit_limit   <= 1'b0;
      timeout_err <= 1'b0;
      rd_payload  <= '0;
    end else begin
      go   <= 1'b0;
      done <= 1'b0;
      unique case (st)
        T_IDLE: if (start) begin
          cmd_q       <= op_cmd;
          read_q      <= op_read;
          pay_q       <= wr_payload;
          lim_q       <= poll_limit;
          half_q      <= (clk_half == '0) ? DIV_W'(1) : clk_half;
          busy        <= 1'b1;
          hit_limit   <= 1'b0;
          timeout_err <= 1'b0;
          pend_k      <= K_CMD;
          cur_k       <= K_POLL0;
          go          <= 1'b1;
          st          <= T_FRAME;
        end
        T_FRAME: if (fin) begin
          st  <= T_GAP;
          gap <= ({2'b00, half_q} << 2) - 1'b1;
          unique case (cur_k)
            K_POLL0: begin
              polls  <= '0;
              next_k <= K_POLLN;
            end
            K_POLLN: begin
              if (rx[READY_BIT]) next_k <= pend_k;
              else if (last_poll) begin
                hit_limit <= 1'b1;
                next_k    <= K_DONE;
              end else begin
                polls  <= polls + 1'b1;
                next_k <= K_POLLN;
              end
            end
            K_CMD: begin
              if (read_q) begin
                pend_k <= K_READ;
                next_k <= K_POLL0;
              end else next_k <= K_DONE;
            end
            default: begin
              rd_payload <= rx_ordered;
              next_k     <= K_DONE;
            end
          endcase
        end
        T_GAP: begin
          if (gap == '0) begin
            if (next_k == K_DONE) begin
              busy        <= 1'b0;
              done        <= 1'b1;
              timeout_err <= hit_limit;
              st          <= T_IDLE;
            end else begin
              cur_k <= next_k;
              go    <= 1'b1;
              st    <= T_FRAME;
            end
          end else gap <= gap - 1'b1;
        end
        default: st <= T_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spe_checker.sv
module spe_checker (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic timeout_err,
  input logic sclk,
  input logic mosi,
  input logic cs_n
);
  assert_sclk_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);

  assert_mosi_steady_while_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && sclk && $past(!cs_n && sclk)) |-> $stable(mosi));

  assert_select_only_when_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n);

  assert_done_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_ends_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_timeout_at_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> done);
endmodule

bind spi_prog_engine spe_checker u_spe_checker (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .timeout_err(timeout_err), .sclk(sclk), .mosi(mosi), .cs_n(cs_n)
);

// File: tb/tb_spi_prog_engine.sv
module tb_spi_prog_engine;
  localparam int CLK_PERIOD = 10;
  localparam int FB   = 136;
  localparam int MAXF = 32;
  localparam int WD   = 180000;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, op_read = 1'b0, miso = 1'b0;
  logic [7:0] op_cmd = '0, poll_limit = '0, clk_half = 8'd1;
  logic [127:0] wr_payload = '0, rd_payload;
  logic busy, done, timeout_err, sclk, mosi, cs_n;

  spi_prog_engine dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_cmd(op_cmd), .op_read(op_read),
    .wr_payload(wr_payload), .poll_limit(poll_limit), .clk_half(clk_half),
    .busy(busy), .done(done), .timeout_err(timeout_err), .rd_payload(rd_payload),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .miso(miso)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;

  task automatic chk(input bit ok, input string req, input logic [135:0] act, input logic [135:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // target model and frame recorder
  logic [135:0] resp, cap;
  logic [135:0] fval [MAXF];
  int flen [MAXF];
  int nfr = 0, bitcnt = 0, sidx = 0, evals = 0, nr_cfg = 0;
  bit prev_status = 0;
  logic [127:0] rd_pat = '0;

  always @(negedge cs_n) begin
    bitcnt = 0; cap = '0; sidx = 0;
    if (!prev_status) resp = {8'h02, rd_pat};
    else resp = {(evals < nr_cfg) ? 8'hFD : 8'h02, rd_pat};
  end
  always @(negedge sclk) if (!cs_n && sidx < FB) begin
    miso <= resp[135 - sidx]; sidx++;
  end
  always @(posedge sclk) if (!cs_n) begin
    cap = {cap[134:0], mosi}; bitcnt++;
  end
  always @(posedge cs_n) begin
    if (nfr < MAXF) begin flen[nfr] = bitcnt; fval[nfr] = cap; end
    nfr++;
    if (bitcnt == 8) begin
      if (prev_status) evals++;
      prev_status = 1;
    end else begin
      prev_status = 0; evals = 0;
    end
  end

  // timing monitor and watchdog
  int hicnt = 0, lowcnt = 0, mingap = 0, lowmin = 0, lowmax = 0;
  always @(negedge clk) begin
    if (cs_n) hicnt++;
    else begin
      if (hicnt > 0 && nfr > 0 && hicnt < mingap) mingap = hicnt;
      hicnt = 0;
    end
    if (!sclk && !cs_n) lowcnt++;
    else if (lowcnt > 0) begin
      if (lowcnt < lowmin) lowmin = lowcnt;
      if (lowcnt > lowmax) lowmax = lowcnt;
      lowcnt = 0;
    end
    cyc++;
    if (cyc > WD) begin
      fails++; checks++;
      $display("FAIL R10 watchdog actual=busy expected=done");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  task automatic run_op(input logic [7:0] c, input bit rd, input logic [127:0] pay,
                        input int lim, input int half, input int nr,
                        input logic [127:0] pat, input bit poke);
    int lim_e, h_e, n, npoll;
    bit tmo;
    int elen [MAXF];
    logic [135:0] eval [MAXF];
    logic [127:0] erd;
    nfr = 0; prev_status = 0; evals = 0; nr_cfg = nr; rd_pat = pat;
    mingap = 1000000; lowmin = 1000000; lowmax = 0; hicnt = 0; lowcnt = 0;
    @(negedge clk);
    op_cmd = c; op_read = rd; wr_payload = pay;
    poll_limit = 8'(lim); clk_half = 8'(half); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke) begin
      repeat (5) @(negedge clk);
      op_cmd = ~c; op_read = !rd; wr_payload = ~pay; poll_limit = 8'd9; clk_half = 8'd2;
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (!done) @(negedge clk);
    lim_e = (lim == 0) ? 1 : lim;
    h_e   = (half == 0) ? 1 : half;
    tmo   = (nr >= lim_e);
    n = 0;
    npoll = 1 + (tmo ? lim_e : nr + 1);
    for (int i = 0; i < npoll; i++) begin elen[n] = 8; eval[n] = 136'hFF; n++; end
    if (!tmo) begin
      elen[n] = FB; eval[n][135:128] = c;
      for (int k = 0; k < 16; k++) eval[n][127-8*k -: 8] = pay[8*k +: 8];
      n++;
      if (rd) begin
        for (int i = 0; i < nr + 2; i++) begin elen[n] = 8; eval[n] = 136'hFF; n++; end
        elen[n] = FB; eval[n] = {8'h05, 128'h0}; n++;
      end
    end
    chk(nfr == n, "R4 frame count", 136'(nfr), 136'(n));
    if (nfr == n) for (int i = 0; i < n; i++) begin
      chk(flen[i] == elen[i], "R5 frame length", 136'(flen[i]), 136'(elen[i]));
      if (elen[i] == 8)
        chk(fval[i][7:0] == 8'hFF, "R4 status byte", 136'(fval[i][7:0]), 136'hFF);
      else if (eval[i][135:128] == 8'h05 && i == n - 1 && rd)
        chk(fval[i] == eval[i], "R6 read frame", fval[i], eval[i]);
      else
        chk(fval[i] == eval[i], "R5 command frame", fval[i], eval[i]);
    end
    chk(timeout_err == tmo, "R8 timeout flag", 136'(timeout_err), 136'(tmo));
    if (rd && !tmo) begin
      for (int k = 0; k < 16; k++) erd[8*k +: 8] = pat[127-8*k -: 8];
      chk(rd_payload == erd, "R6 read data", 136'(rd_payload), 136'(erd));
    end
    chk(lowmin == h_e && lowmax == h_e, "R3 half period", 136'(lowmax), 136'(h_e));
    if (n > 1) chk(mingap >= 4 * h_e, "R7 chip-select gap", 136'(mingap), 136'(4 * h_e));
    @(negedge clk);
    chk(!busy && !done, "R10 idle after done", 136'({busy, done}), 136'(0));
  endtask

  initial begin
    logic [127:0] p, q, keep;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && sclk && !busy && !done && !timeout_err, "R1 reset state",
        136'({cs_n, sclk, busy, done, timeout_err}), 136'(5'b11000));
    // R2 R3 R4 R5 R6 R8 sweep
    for (int h = 1; h <= 3; h++)
      for (int nr = 0; nr <= 2; nr++)
        for (int rd = 0; rd <= 1; rd++) begin
          for (int k = 0; k < 16; k++) begin
            p[8*k +: 8] = 8'(h * 37 + nr * 11 + k * 13 + rd);
            q[8*k +: 8] = 8'(k * 29 + h * 7 + nr + 3);
          end
          run_op(rd ? ((nr % 2) ? 8'h21 : 8'h18) : ((h % 2) ? 8'h01 : 8'h04),
                 bit'(rd), p, 2, h, nr, q, 1'b0);
        end
    // R8 zero limit acts as one; R10 hold of rd_payload across a timeout
    keep = rd_payload;
    run_op(8'h21, 1'b1, '0, 0, 2, 1, ~q, 1'b0);
    chk(rd_payload == keep, "R10 read data held", 136'(rd_payload), 136'(keep));
    // R3 zero divider acts as one, longer poll run
    run_op(8'h18, 1'b1, p, 5, 0, 4, 128'h0123456789ABCDEF_FEDCBA9876543210, 1'b0);
    // R9 start during busy ignored
    run_op(8'h01, 1'b0, 128'hA5A5_0F0F_1234_5678_9ABC_DEF0_55AA_C3C3, 3, 1, 1, q, 1'b1);
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule